// File: doc/BRIEF.md
# AES-128 Iterative Block Encryptor

This block enciphers a single 128-bit plaintext under a 128-bit key using the AES-128 forward cipher. A one-cycle load pulse captures both operands and performs the initial key whitening in the same edge. After that, one full round is computed per clock for ten clocks. The expanded key for each round is derived in the same cycle it is consumed. When the tenth round is written, a completion flag rises, and the ciphertext output carries the result.

The byte substitution has no stored table. Each substitution unit computes the multiplicative inverse in GF(2^8) by raising its input to the power 254 and then applies the fixed affine transform. The same unit serves both the state path (sixteen instances) and the key path (four instances). Byte k of a 128-bit word sits in bits [127-8k -: 8], and the state is read column by column, four bytes to a column.

The completion flag and the ciphertext stay unchanged until another load is accepted. A load that arrives while a block is in flight is dropped. Driving the active-low reset low at any time aborts the block and returns the control to idle.

Top module: `aes128_enc_core`

## Requirements
- R1: While reset is applied and after it is released, `done_o` is 0 until a block has completed.
- R2: Key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff yield ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: Key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734 yield ciphertext 3925841d02dc09fbdc118597196a0b32.
- R4: An all-zero key with an all-zero plaintext yields 66e94bd4ef8a2c3b884cfa59ca342b2e. This exercises the inverse-of-zero case of the substitution.
- R5: `done_o` rises at the 10th rising edge after the edge that accepts `load_i`, and it stays low in between.
- R6: Once high, `done_o` stays high and `ciphertext_o` stays unchanged until the next accepted load.
- R7: A `load_i` pulse while a block is in progress is ignored. The running block completes with its own result, and no extra completion follows.
- R8: A load accepted while `done_o` is high clears `done_o` at that edge and starts a new block.
- R9: Asserting `rst_n` low in the middle of a block abandons it. `done_o` stays low afterwards, and the next load is processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| load_i | input | 1 | Start pulse; captures plaintext and key when idle |
| plaintext_i | input | 128 | Block to encrypt, byte 0 in bits 127:120 |
| key_i | input | 128 | Cipher key, byte 0 in bits 127:120 |
| ciphertext_o | output | 128 | Encrypted block, valid while done_o is high |
| done_o | output | 1 | Completion flag, held until the next accepted load |

## Verification
The hardest situations to reach from the ports are a second load landing mid-flight and a reset cutting a block off halfway. Both leave no trace unless the scoreboard knows exactly which completions to expect. For the mid-flight case, the bench issues a normal load and then, a few cycles later, pulses load again with different operands while the first block is still running. It then confirms that only the first block's ciphertext appears, with the original latency, and that no second completion ever follows. For the abort case, the bench starts a block that it deliberately does not enqueue, pulls reset three rounds in, and checks that no completion surfaces. A fresh block is then run to show that the core recovers cleanly.

// File: rtl/aes_pkg.sv
package aes_pkg;

  localparam int unsigned BLOCK_W = 128;
  localparam int unsigned BYTES   = BLOCK_W / 8;
  localparam logic [7:0]  POLY_LO = 8'h1b;
  localparam logic [7:0]  AFF_C   = 8'h63;

  typedef logic [BLOCK_W-1:0] block_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? POLY_LO : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // a^254 = a^-1 for a != 0, and 0 for a == 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) begin
      y[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ AFF_C[i];
    end
    return y;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] in_b,
  output logic [7:0] out_b
);
  logic [7:0] inv_b;

  always_comb begin
    inv_b = aes_pkg::gf_inv(in_b);
    out_b = aes_pkg::affine(inv_b);
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step (
  input  aes_pkg::block_t rk_i,
  input  logic [7:0]      rcon_i,
  output aes_pkg::block_t rk_o
);
  logic [31:0] w0, w1, w2, w3, rot, sub, tmp;

  assign w0  = rk_i[127:96];
  assign w1  = rk_i[95:64];
  assign w2  = rk_i[63:32];
  assign w3  = rk_i[31:0];
  assign rot = {w3[23:0], w3[31:24]};

  for (genvar b = 0; b < 4; b++) begin : g_sub
    aes_sbox u_sb (.in_b(rot[31-8*b -: 8]), .out_b(sub[31-8*b -: 8]));
  end

  assign tmp = sub ^ {rcon_i, 24'h000000};

  always_comb begin
    rk_o[127:96] = w0 ^ tmp;
    rk_o[95:64]  = w1 ^ w0 ^ tmp;
    rk_o[63:32]  = w2 ^ w1 ^ w0 ^ tmp;
    rk_o[31:0]   = w3 ^ w2 ^ w1 ^ w0 ^ tmp;
  end
endmodule

// File: rtl/aes_round.sv
module aes_round (
  input  aes_pkg::block_t st_i,
  input  aes_pkg::block_t rk_i,
  input  logic            final_i,
  output aes_pkg::block_t st_o
);
  import aes_pkg::*;

  block_t sb, sh, mx;

  for (genvar k = 0; k < BYTES; k++) begin : g_sub
    aes_sbox u_sb (.in_b(st_i[127-8*k -: 8]), .out_b(sb[127-8*k -: 8]));
  end

  // row r of column c takes the byte from column (c+r) mod 4
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sh[127-8*(4*c+r) -: 8] = sb[127-8*(4*((c+r)%4)+r) -: 8];
      assign mx[127-8*(4*c+r) -: 8] =
          xtime(sh[127-8*(4*c+r) -: 8]) ^
          xtime(sh[127-8*(4*c+(r+1)%4) -: 8]) ^ sh[127-8*(4*c+(r+1)%4) -: 8] ^
          sh[127-8*(4*c+(r+2)%4) -: 8] ^ sh[127-8*(4*c+(r+3)%4) -: 8];
    end
  end

  assign st_o = (final_i ? sh : mx) ^ rk_i;
endmodule

// File: rtl/aes128_enc_core.sv
module aes128_enc_core #(
  parameter int unsigned ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [127:0] plaintext_i,
  input  logic [127:0] key_i,
  output logic [127:0] ciphertext_o,
  output logic         done_o
);
  import aes_pkg::*;

  localparam int unsigned RW = $clog2(ROUNDS + 1);

  block_t        state_q, state_d, rkey_q, rkey_d, rk_next, rnd_out;
  logic [7:0]    rcon_q, rcon_d;
  logic [RW-1:0] round_q, round_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic          last_rnd, start;

  assign last_rnd = (round_q == RW'(ROUNDS));
  assign start    = load_i && !busy_q;

  aes_key_step u_key (.rk_i(rkey_q), .rcon_i(rcon_q), .rk_o(rk_next));
  aes_round    u_rnd (.st_i(state_q), .rk_i(rk_next), .final_i(last_rnd), .st_o(rnd_out));

  always_comb begin
    state_d = state_q;
    rkey_d  = rkey_q;
    rcon_d  = rcon_q;
    round_d = round_q;
    busy_d  = busy_q;
    done_d  = done_q;
    if (start) begin
      state_d = plaintext_i ^ key_i;
      rkey_d  = key_i;
      rcon_d  = 8'h01;
      round_d = RW'(1);
      busy_d  = 1'b1;
      done_d  = 1'b0;
    end else if (busy_q) begin
      state_d = rnd_out;
      rkey_d  = rk_next;
      rcon_d  = xtime(rcon_q);
      round_d = round_q + RW'(1);
      if (last_rnd) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      rkey_q  <= '0;
      rcon_q  <= 8'h00;
      round_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (start || busy_q) begin
        state_q <= state_d;
        rkey_q  <= rkey_d;
        rcon_q  <= rcon_d;
        round_q <= round_d;
      end
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign ciphertext_o = state_q;
  assign done_o       = done_q;
endmodule

// File: rtl/aes128_enc_chk.sv
module aes128_enc_chk #(
  parameter int unsigned ROUNDS = 10,
  parameter int unsigned RW     = $clog2(ROUNDS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic [127:0]  ciphertext_o,
  input logic          done_o,
  input logic          busy_q,
  input logic [RW-1:0] round_q
);
  logic          armed_q;
  logic [RW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lat_q   <= '0;
    end else if (load_i && !busy_q) begin
      armed_q <= 1'b1;
      lat_q   <= '0;
    end else if (armed_q) begin
      lat_q   <= lat_q + RW'(1);
      if (lat_q == RW'(ROUNDS - 1)) armed_q <= 1'b0;
    end
  end

  p_quiet_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> !done_o);

  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && lat_q == RW'(ROUNDS - 1)) |=> done_o);

  p_round_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (round_q >= RW'(1) && round_q <= RW'(ROUNDS)));

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> (done_o && $stable(ciphertext_o)));

  p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load_i && round_q != RW'(ROUNDS)) |=> (busy_q && round_q == $past(round_q) + RW'(1)));

  p_reload_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && load_i) |=> !done_o);
endmodule

bind aes128_enc_core aes128_enc_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .ciphertext_o(ciphertext_o),
  .done_o(done_o), .busy_q(busy_q), .round_q(round_q)
);

// File: tb/tb_aes128_enc_core.sv
module tb_aes128_enc_core;
  localparam int ROUNDS = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i;
  logic [127:0] plaintext_i, key_i;
  logic [127:0] ciphertext_o;
  logic         done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [127:0] exp_ct_q[$];
  int           exp_cyc_q[$];
  string        exp_tag_q[$];

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C3 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aes128_enc_core #(.ROUNDS(ROUNDS)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .plaintext_i(plaintext_i),
    .key_i(key_i), .ciphertext_o(ciphertext_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: pulse load for one cycle, optionally enqueue the expected result
  task automatic drive(input logic [127:0] pt, input logic [127:0] k,
                       input logic [127:0] ct, input bit expect_it, input string tag);
    @(negedge clk);
    plaintext_i = pt;
    key_i       = k;
    load_i      = 1'b1;
    if (expect_it) begin
      exp_ct_q.push_back(ct);
      exp_cyc_q.push_back(cyc + 1 + ROUNDS);
      exp_tag_q.push_back(tag);
    end
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && exp_ct_q.size() != 0; i++) @(negedge clk);
  endtask

  // monitor: compare each completion against the scoreboard
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && !done_prev) begin
        if (exp_ct_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R7: unexpected completion actual %h expected none", ciphertext_o);
        end else begin
          automatic logic [127:0] e = exp_ct_q.pop_front();
          automatic int           c = exp_cyc_q.pop_front();
          automatic string        t = exp_tag_q.pop_front();
          check(ciphertext_o == e, t, ciphertext_o, e);
          check(cyc == c, "R5 latency", 128'(cyc), 128'(c));
        end
      end
      done_prev <= done_o;
    end else begin
      done_prev <= 1'b0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] held;
    rst_n = 1'b0; load_i = 1'b0; plaintext_i = '0; key_i = '0;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 in reset", 128'(done_o), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R1 after reset", 128'(done_o), 128'(0));

    drive(P1, K1, C1, 1'b1, "R2");
    drain();
    // R6: result held while idle
    held = ciphertext_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(done_o && ciphertext_o == held, "R6 hold", ciphertext_o, held);
    end

    // R8: load while done clears done at once
    drive(P2, K2, C2, 1'b1, "R3");
    check(done_o == 1'b0, "R8 clear", 128'(done_o), 128'(0));
    drain();

    drive('0, '0, C3, 1'b1, "R4");
    drain();

    // R7: second load mid-flight must be dropped
    drive(P1, K1, C1, 1'b1, "R7 first block");
    repeat (3) @(negedge clk);
    plaintext_i = P2; key_i = K2; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    drain();
    repeat (15) @(negedge clk);
    check(done_o && ciphertext_o == C1, "R7 result kept", ciphertext_o, C1);
    check(exp_ct_q.size() == 0, "R7 queue", 128'(exp_ct_q.size()), 128'(0));

    // R9: reset in mid-block
    drive(P2, K2, C2, 1'b0, "");
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R9 in reset", 128'(done_o), 128'(0));
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    check(done_o == 1'b0, "R9 aborted", 128'(done_o), 128'(0));
    drive(P2, K2, C2, 1'b1, "R9 recovery");
    drain();
    repeat (3) @(negedge clk);
    check(exp_ct_q.size() == 0, "R9 queue", 128'(exp_ct_q.size()), 128'(0));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule